// File: doc/BRIEF.md
# Firmware Load Command Block Generator

This block turns a firmware section image into the list of command blocks that a DMA engine later executes to copy the section into device memory. The section is a sequence of records. Each record has an 8-byte header and then its payload bytes. The header holds the destination address first and the payload length second. The generator reads only the headers, through a word-read port into the source buffer. It then writes the command blocks through a sequential word-write port into the target memory.

Software gives the block the bus address of the source buffer and the section length in bytes, then pulses `start`. Each record is split into chunks of bounded size. For every chunk the block writes four words, and it closes the list with a single zero word whose address it reports. A record whose payload or header extends past the section end stops the walk and raises an error instead. The DMA engine that consumes the list is a separate block.

Top module: `fwld_cmd_gen`

## Requirements
- R1: The 32-bit header words are read from byte offsets within the section in little-endian order (byte at offset k is bits 7:0). The destination word is at the record offset and the length word is at offset + 4. The next record starts directly after the payload.
- R2: The source address of a record's first chunk is `src_base` + record offset + 8.
- R3: A payload is cut into chunks of at most 8191 bytes, taken in order. Every chunk except the last has exactly 8191 bytes. From one chunk to the next, source and destination both advance by the previous chunk length.
- R4: The first word of each command block is 0x8CEA0000 ORed with the chunk length in bits 15:0.
- R5: Each command block is written as control, source, destination, checksum, where checksum = control ^ source ^ destination.
- R6: The first write of a run goes to target address 0x27000, and each later write goes to the previous address + 4.
- R7: A record of length zero produces no command block, and parsing resumes at the next header 8 bytes later.
- R8: When the walk reaches the section end exactly, one zero word is written. `sentinel_addr` holds that word's address, and `done` rises in the same cycle as that write.
- R9: If a header (offset + 8) or a payload (offset + 8 + length) extends past `sect_len`, `err` rises. No word of that record and no zero word is written, and `done` stays low.
- R10: After reset the block is idle, with `busy`, `done`, `err`, `wr_en` and `rd_req` low.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress completes with the parameters it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only while idle |
| src_base | input | 32 | Bus address of the source buffer |
| sect_len | input | 32 | Section length in bytes |
| rd_req | output | 1 | Header word read request |
| rd_addr | output | 32 | Byte offset of the requested word within the section |
| rd_data | input | 32 | Little-endian word, valid one cycle after the request is sampled |
| wr_en | output | 1 | Target write strobe |
| wr_addr | output | 32 | Target word address |
| wr_data | output | 32 | Target write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | List finished with zero word |
| err | output | 1 | Section overrun detected |
| sentinel_addr | output | 32 | Address of the zero word of the last finished run |

## Verification
The bench aims at the chunk boundary. Lengths of 8191, 8192 and 16383 catch an off-by-one split, which would either emit an oversized control word or drop a one-byte tail chunk. Odd payload lengths place the following headers at unaligned offsets, so byte-order or alignment mistakes show up as wrong destination words. Zero-length records and an empty section check that no empty command block is produced and that the zero word then lands at the base address. Truncated sections, cut both inside a payload and inside a header, confirm that a generator which failed to check bounds would be caught writing blocks for the partial record or a sentinel.

// File: rtl/fwld_pkg.sv
package fwld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_HDR2,
    ST_LEN,
    ST_W0,
    ST_W1,
    ST_W2,
    ST_W3,
    ST_SENT
  } gen_state_t;

  localparam int HDR_BYTES = 8;
  localparam int LEN_OFS   = 4;

endpackage

// File: rtl/fwld_bound_chk.sv
module fwld_bound_chk #(
  parameter int W = 32
) (
  input  logic [W-1:0] off,
  input  logic [W-1:0] sect_len,
  input  logic [W-1:0] hdr_len,
  output logic         at_end,
  output logic         hdr_over,
  output logic         body_over,
  output logic [W-1:0] next_off
);
  localparam int XW = W + 2;
  localparam logic [XW-1:0] HDR_X = XW'(fwld_pkg::HDR_BYTES);

  logic [XW-1:0] hdr_end;
  logic [XW-1:0] body_end;
  logic [XW-1:0] lim;

  always_comb begin
    lim       = {2'b00, sect_len};
    hdr_end   = {2'b00, off} + HDR_X;
    body_end  = hdr_end + {2'b00, hdr_len};
    at_end    = (off == sect_len);
    hdr_over  = (hdr_end > lim);
    body_over = (body_end > lim);
    next_off  = body_end[W-1:0];
  end
endmodule

// File: rtl/fwld_chunk_calc.sv
module fwld_chunk_calc #(
  parameter int          W         = 32,
  parameter int          MAX_CHUNK = 8191,
  parameter logic [31:0] CTL_BASE  = 32'h8CEA_0000
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] mlen,
  output logic [W-1:0] ctl,
  output logic [W-1:0] sum
);
  localparam logic [W-1:0] MAXC = W'(MAX_CHUNK);
  localparam logic [W-1:0] TAG  = W'(CTL_BASE);

  always_comb begin
    mlen = (rem > MAXC) ? MAXC : rem;
    ctl  = TAG | mlen;
    sum  = ctl ^ src ^ dst;
  end
endmodule

// File: rtl/fwld_tgt_writer.sv
module fwld_tgt_writer #(
  parameter int          W        = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] TGT_BASE = 32'h0002_7000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);
  localparam logic [AW-1:0] BASE = AW'(TGT_BASE);
  localparam logic [AW-1:0] STEP = AW'(W / 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= BASE;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= push;
      if (restart) begin
        ptr <= BASE;
      end else if (push) begin
        ptr     <= ptr + STEP;
        wr_addr <= ptr;
        wr_data <= din;
      end
    end
  end
endmodule

// File: rtl/fwld_cmd_gen.sv
module fwld_cmd_gen #(
  parameter int          W         = 32,
  parameter int          TGT_AW    = 32,
  parameter logic [31:0] TGT_BASE  = 32'h0002_7000,
  parameter int          MAX_CHUNK = 8191,
  parameter logic [31:0] CTL_BASE  = 32'h8CEA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      src_base,
  input  logic [W-1:0]      sect_len,
  output logic              rd_req,
  output logic [W-1:0]      rd_addr,
  input  logic [W-1:0]      rd_data,
  output logic              wr_en,
  output logic [TGT_AW-1:0] wr_addr,
  output logic [W-1:0]      wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [TGT_AW-1:0] sentinel_addr
);
  import fwld_pkg::*;

  localparam logic [W-1:0] HDR_W = W'(HDR_BYTES);
  localparam logic [W-1:0] LEN_W = W'(LEN_OFS);

  gen_state_t state;

  logic [W-1:0] base_q, slen_q, off_q, nxt_q;
  logic [W-1:0] src_q, dst_q, rem_q;

  logic          at_end, hdr_over, body_over;
  logic [W-1:0]  next_off;
  logic [W-1:0]  mlen, ctl, sum;
  logic          push, restart;
  logic [W-1:0]  din;
  logic [TGT_AW-1:0] wr_ptr;

  fwld_bound_chk #(.W(W)) u_bound (
    .off      (off_q),
    .sect_len (slen_q),
    .hdr_len  (rd_data),
    .at_end   (at_end),
    .hdr_over (hdr_over),
    .body_over(body_over),
    .next_off (next_off)
  );

  fwld_chunk_calc #(.W(W), .MAX_CHUNK(MAX_CHUNK), .CTL_BASE(CTL_BASE)) u_chunk (
    .rem (rem_q),
    .src (src_q),
    .dst (dst_q),
    .mlen(mlen),
    .ctl (ctl),
    .sum (sum)
  );

  fwld_tgt_writer #(.W(W), .AW(TGT_AW), .TGT_BASE(TGT_BASE)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .push   (push),
    .din    (din),
    .ptr    (wr_ptr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  assign busy    = (state != ST_IDLE);
  assign restart = (state == ST_IDLE) && start;

  always_comb begin
    push = 1'b0;
    din  = '0;
    unique case (state)
      ST_W0:   begin push = 1'b1; din = ctl;   end
      ST_W1:   begin push = 1'b1; din = src_q; end
      ST_W2:   begin push = 1'b1; din = dst_q; end
      ST_W3:   begin push = 1'b1; din = sum;   end
      ST_SENT: begin push = 1'b1; din = '0;    end
      default: begin push = 1'b0; din = '0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      base_q        <= '0;
      slen_q        <= '0;
      off_q         <= '0;
      nxt_q         <= '0;
      src_q         <= '0;
      dst_q         <= '0;
      rem_q         <= '0;
      rd_req        <= 1'b0;
      rd_addr       <= '0;
      done          <= 1'b0;
      err           <= 1'b0;
      sentinel_addr <= '0;
    end else begin
      rd_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= src_base;
            slen_q <= sect_len;
            off_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            state  <= ST_HDR0;
          end
        end
        ST_HDR0: begin
          if (at_end) begin
            state <= ST_SENT;
          end else if (hdr_over) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= off_q;
            state   <= ST_HDR1;
          end
        end
        ST_HDR1: begin
          rd_req  <= 1'b1;
          rd_addr <= off_q + LEN_W;
          state   <= ST_HDR2;
        end
        ST_HDR2: begin
          dst_q <= rd_data;
          state <= ST_LEN;
        end
        ST_LEN: begin
          if (body_over) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (rd_data == '0) begin
            off_q <= off_q + HDR_W;
            state <= ST_HDR0;
          end else begin
            rem_q <= rd_data;
            src_q <= base_q + off_q + HDR_W;
            nxt_q <= next_off;
            state <= ST_W0;
          end
        end
        ST_W0: state <= ST_W1;
        ST_W1: state <= ST_W2;
        ST_W2: state <= ST_W3;
        ST_W3: begin
          rem_q <= rem_q - mlen;
          src_q <= src_q + mlen;
          dst_q <= dst_q + mlen;
          if (rem_q == mlen) begin
            off_q <= nxt_q;
            state <= ST_HDR0;
          end else begin
            state <= ST_W0;
          end
        end
        ST_SENT: begin
          sentinel_addr <= wr_ptr;
          done          <= 1'b1;
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fwld_cmd_gen_chk.sv
module fwld_cmd_gen_chk #(
  parameter int          W         = 32,
  parameter int          TGT_AW    = 32,
  parameter logic [31:0] TGT_BASE  = 32'h0002_7000,
  parameter int          MAX_CHUNK = 8191,
  parameter logic [31:0] CTL_BASE  = 32'h8CEA_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              rd_req,
  input logic              wr_en,
  input logic [TGT_AW-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic              done,
  input logic              err,
  input logic [TGT_AW-1:0] sentinel_addr
);
  localparam logic [TGT_AW-1:0] BASE = TGT_AW'(TGT_BASE);
  localparam logic [TGT_AW-1:0] STEP = TGT_AW'(W / 8);

  logic [1:0]        phase;
  logic              have_prev, first;
  logic [TGT_AW-1:0] prev_addr;
  logic [W-1:0]      w0, w1, w2;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      have_prev <= 1'b0;
      first     <= 1'b0;
      prev_addr <= '0;
      w0        <= '0;
      w1        <= '0;
      w2        <= '0;
    end else if (start && !busy) begin
      phase     <= '0;
      have_prev <= 1'b0;
      first     <= 1'b1;
    end else if (wr_en) begin
      have_prev <= 1'b1;
      first     <= 1'b0;
      prev_addr <= wr_addr;
      if (!(phase == 2'd0 && wr_data == '0)) phase <= phase + 2'd1;
      case (phase)
        2'd0:    w0 <= wr_data;
        2'd1:    w1 <= wr_data;
        2'd2:    w2 <= wr_data;
        default: ;
      endcase
    end
  end

  assert_first_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && first) |-> (wr_addr == BASE));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_prev) |-> (wr_addr == prev_addr + STEP));

  assert_ctl_word_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase == 2'd0 && wr_data != '0) |->
      (wr_data[31:16] == CTL_BASE[31:16] && wr_data[15:0] != 16'd0 &&
       32'(wr_data[15:0]) <= 32'(MAX_CHUNK)));

  assert_checksum_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase == 2'd3) |-> (wr_data == (w0 ^ w1 ^ w2)));

  assert_sentinel_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (wr_en && wr_data == '0 && wr_addr == sentinel_addr));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (!wr_en && !done));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!wr_en && !rd_req));
endmodule

bind fwld_cmd_gen fwld_cmd_gen_chk #(
  .W(W), .TGT_AW(TGT_AW), .TGT_BASE(TGT_BASE),
  .MAX_CHUNK(MAX_CHUNK), .CTL_BASE(CTL_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .rd_req       (rd_req),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .done         (done),
  .err          (err),
  .sentinel_addr(sentinel_addr)
);

// File: tb/test_fwld_cmd_gen.sv
`timescale 1ns/1ps
module test_fwld_cmd_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_base = '0;
  logic [31:0] sect_len = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        busy, done, err;
  logic [31:0] sentinel_addr;

  always #2.5 clk = ~clk;

  fwld_cmd_gen i_fwld_cmd_gen (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .sect_len(sect_len),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err), .sentinel_addr(sentinel_addr)
  );

  logic [7:0] mem [0:131071];
  always @(posedge clk) begin
    if (rd_req)
      rd_data <= {mem[rd_addr[16:0] + 17'd3], mem[rd_addr[16:0] + 17'd2],
                  mem[rd_addr[16:0] + 17'd1], mem[rd_addr[16:0]]};
  end

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rec_dst [0:7];
  int          rec_len [0:7];
  logic [31:0] exp_w [0:255];
  logic [31:0] got_w [0:255];
  logic [31:0] got_a [0:255];
  int exp_n, got_n;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put_word(input int off, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(off + k) % 131072] = v[8*k +: 8];
  endtask

  task automatic add_chunks(input logic [31:0] base, input int off, input int idx);
    logic [31:0] s, d, c, m;
    int rem;
    s = base + 32'(off) + 32'd8;
    d = rec_dst[idx];
    rem = rec_len[idx];
    while (rem > 0) begin
      m = (rem > 8191) ? 32'd8191 : 32'(rem);
      c = 32'h8CEA0000 | m;
      exp_w[exp_n] = c; exp_w[exp_n+1] = s; exp_w[exp_n+2] = d; exp_w[exp_n+3] = c ^ s ^ d;
      exp_n += 4;
      s += m; d += m; rem -= int'(m);
    end
  endtask

  // Runs n records from rec_dst/rec_len; trunc > 0 cuts the section short.
  task automatic run(input int n, input logic [31:0] base, input int trunc,
                     input bit poke, input string name);
    int off, wd;
    bit exp_err, timeout;
    logic [31:0] sent_exp;
    string t;
    off = 0; exp_n = 0; got_n = 0;
    for (int i = 0; i < n; i++) begin
      put_word(off, rec_dst[i]);
      put_word(off + 4, 32'(rec_len[i]));
      if (i < n - 1 || trunc == 0) add_chunks(base, off, i);
      off += 8 + rec_len[i];
    end
    exp_err = (trunc > 0);
    sent_exp = 32'h27000 + 32'(exp_n) * 4;
    if (!exp_err) begin exp_w[exp_n] = 32'h0; exp_n++; end
    @(negedge clk);
    src_base = base; sect_len = 32'(off - trunc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wd = 0; timeout = 0;
    while (!(done || err) && !timeout) begin
      if (wr_en && got_n < 256) begin got_w[got_n] = wr_data; got_a[got_n] = wr_addr; got_n++; end
      if (poke && wd == 3) begin
        src_base = base ^ 32'h1000; sect_len = 32'(off + 100); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      wd++;
      if (wd > 30000) timeout = 1;
    end
    start = 1'b0;
    chk(!timeout, "R8", {name, " run finished"}, 32'(wd), 32'd30000);
    for (int k = 0; k < 3; k++) begin
      if (wr_en && got_n < 256) begin got_w[got_n] = wr_data; got_a[got_n] = wr_addr; got_n++; end
      @(negedge clk);
    end
    chk(done == !exp_err, "R8", {name, " done"}, 32'(done), 32'(!exp_err));
    chk(err == exp_err, "R9", {name, " err"}, 32'(err), 32'(exp_err));
    chk(got_n == exp_n, poke ? "R11" : "R3", {name, " write count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (!exp_err && i == exp_n - 1) t = "R8";
      else case (i % 4)
        0: t = "R4";
        1: t = "R2";
        2: t = "R1";
        default: t = "R5";
      endcase
      chk(got_w[i] == exp_w[i], t, {name, " word"}, got_w[i], exp_w[i]);
      chk(got_a[i] == 32'h27000 + 32'(i) * 4, "R6", {name, " address"},
          got_a[i], 32'h27000 + 32'(i) * 4);
    end
    if (!exp_err)
      chk(sentinel_addr == sent_exp, "R8", {name, " sentinel_addr"}, sentinel_addr, sent_exp);
  endtask

  function automatic int pick_len();
    case ($urandom % 6)
      0: return 0;
      1: return int'($urandom % 64);
      2: return 8191;
      3: return 8192;
      4: return 8190 + int'($urandom % 4);
      default: return int'($urandom % 16384);
    endcase
  endfunction

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 131072; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !wr_en && !rd_req, "R10", "reset state",
        {27'd0, busy, done, err, wr_en, rd_req}, 32'd0);

    // Single record exactly one maximal chunk.
    rec_dst[0] = 32'h0010_0000; rec_len[0] = 8191;
    run(1, 32'h4000_0000, 0, 0, "max chunk");
    // One past the limit: tail chunk of 1 byte.
    rec_dst[0] = 32'h0020_0004; rec_len[0] = 8192;
    run(1, 32'h1234_5670, 0, 0, "split 8192");
    // R7: zero-length records around an odd-length one.
    rec_dst[0] = 32'hAAAA_0000; rec_len[0] = 0;
    rec_dst[1] = 32'h0000_1000; rec_len[1] = 5;
    rec_dst[2] = 32'hBBBB_0000; rec_len[2] = 0;
    rec_dst[3] = 32'h0000_2000; rec_len[3] = 16383;
    run(4, 32'h0800_0000, 0, 0, "R7 zero-length");
    // Empty section: sentinel at base.
    run(0, 32'h0, 0, 0, "empty section");
    // R9: payload overrun by one byte.
    rec_dst[0] = 32'h0000_3000; rec_len[0] = 100;
    rec_dst[1] = 32'h0000_4000; rec_len[1] = 9000;
    run(2, 32'h2000_0000, 1, 0, "R9 payload overrun");
    // R9: header cut short.
    rec_dst[0] = 32'h0000_5000; rec_len[0] = 13;
    rec_dst[1] = 32'h0000_6000; rec_len[1] = 0;
    run(2, 32'h2000_0000, 3, 0, "R9 header overrun");
    // R11: start pulse mid-run ignored.
    rec_dst[0] = 32'h0030_0000; rec_len[0] = 9000;
    rec_dst[1] = 32'h0031_0000; rec_len[1] = 7;
    run(2, 32'h5000_0000, 0, 1, "R11 start while busy");

    for (int r = 0; r < 12; r++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
        rec_dst[i] = $urandom;
        rec_len[i] = pick_len();
      end
      run(n, $urandom, (r % 4 == 3) ? 1 + int'($urandom % 6) : 0, 0, "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule